// File: doc/BRIEF.md
# Segmented Linear Address Unit

This block turns an operand reference into a 32-bit linear address. It holds six segment slots. Each slot keeps a selector and a cached descriptor: base, 20-bit limit, granularity flag, descriptor privilege level and present flag. A request names one slot and one of eight address-mode codes. It also carries base-register, index-register, scale, displacement, program-counter and current-privilege inputs. The unit forms the offset for the chosen mode, adds the segment base, and checks the access against the cached descriptor.

Descriptors are loaded through a simple write port. A load takes effect for requests issued from the following cycle on. The result appears one clock after the request, together with a fault flag and a two-bit fault code. The three checks are segment absence, privilege and limit, and they are ranked in that order. Paging is not part of the block.

Top module: `seg_linear_unit`

## Requirements
- R1: After reset `lin_valid`, `fault` and `fault_kind` are 0, `lin_addr` is 0, and all six slots are unusable (not present, base 0).
- R2: A request accepted on one rising edge is reported on the next: `lin_valid` follows `req_valid` with one cycle of latency. Cycles without a request give `lin_valid`=0 and `fault`=0, and `lin_addr` keeps its last value.
- R3: The offset depends on `req_mode`. 0 gives disp. 1 gives base. 2 gives base+disp. 3 gives (index<<scale)+disp. 4 gives base+index+disp. 5 gives base+(index<<scale)+disp. Code 7 behaves as code 0. `req_scale` is a left-shift count (×1, ×2, ×4, ×8) and is used only by codes 3 and 5.
- R4: All sums wrap modulo 2^32. This covers the offset sum and the final base+offset sum.
- R5: Mode 6 (relative) outputs pc+disp. It adds no segment base and never faults, even on an absent segment.
- R6: A descriptor write to slot `desc_wr_seg` stores base, limit, granularity, privilege, present and the selector. Selector bits 1:0 are the requested privilege level. The new values serve requests from the next cycle. A request in the same cycle as the write still sees the old descriptor.
- R7: Fault code 1 (absent) has top priority. It is raised when the present flag is clear, the slot number is 6 or 7, or the stored selector has bits 15:2 all zero (null selector).
- R8: Fault code 2 (privilege) is raised when the larger of `req_cpl` and the selector's requested level is numerically greater than the descriptor privilege level. Level 0 is most privileged.
- R9: Fault code 3 (limit) is raised when the offset is greater than the effective limit. With granularity clear the effective limit is the 20-bit limit. With granularity set it is limit·4096+4095.
- R10: `fault` is 1 exactly when `fault_kind` is non-zero. `lin_addr` still carries the computed address when a fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_wr_en | input | 1 | Descriptor write strobe |
| desc_wr_seg | input | 3 | Slot number written |
| desc_wr_selector | input | 16 | Selector (bits 1:0 requested level, 2 table flag, 15:3 index) |
| desc_wr_base | input | 32 | Segment base |
| desc_wr_limit | input | 20 | Segment limit |
| desc_wr_gran | input | 1 | Limit counted in 4 KB units |
| desc_wr_dpl | input | 2 | Descriptor privilege level |
| desc_wr_present | input | 1 | Segment present |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 3 | Slot used by the request |
| req_mode | input | 3 | Address-mode code |
| req_base | input | 32 | Base-register value |
| req_index | input | 32 | Index-register value |
| req_scale | input | 2 | Index shift count |
| req_disp | input | 32 | Displacement |
| req_pc | input | 32 | Program counter for relative mode |
| req_cpl | input | 2 | Current privilege level |
| lin_valid | output | 1 | Result valid |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Any fault |
| fault_kind | output | 2 | 0 none, 1 absent, 2 privilege, 3 limit |

## Verification
The bench builds the unit with its default parameters: six slots, 32-bit addresses, a 20-bit limit with a 12-bit granularity shift, and both the scaled-index and granularity variants enabled. With these values the exact 4 KB-scaled limit edge and the full 4 GB limit can be reached. So can the wrap of base+offset past 2^32 and the out-of-range slot numbers 6 and 7. Every shift count of the scale field is also reachable.

// File: rtl/seg_pkg.sv
package seg_pkg;

   typedef enum logic [2:0] {
      AM_DISP       = 3'd0,
      AM_BASE       = 3'd1,
      AM_BASE_DISP  = 3'd2,
      AM_SIDX_DISP  = 3'd3,
      AM_BIDX_DISP  = 3'd4,
      AM_BSIDX_DISP = 3'd5,
      AM_REL        = 3'd6,
      AM_RSVD       = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      FK_NONE   = 2'd0,
      FK_ABSENT = 2'd1,
      FK_PRIV   = 2'd2,
      FK_LIMIT  = 2'd3
   } fkind_e;

endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
   parameter int NUM_SEGS = 6,
   parameter int SEG_W    = 3,
   parameter int AW       = 32,
   parameter int SEL_W    = 16,
   parameter int LIMIT_W  = 20,
   parameter int PL_W     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEG_W-1:0]   wr_seg,
   input  logic [SEL_W-1:0]   wr_selector,
   input  logic [AW-1:0]      wr_base,
   input  logic [LIMIT_W-1:0] wr_limit,
   input  logic               wr_gran,
   input  logic [PL_W-1:0]    wr_dpl,
   input  logic               wr_present,
   input  logic [SEG_W-1:0]   rd_seg,
   output logic               rd_usable,
   output logic [AW-1:0]      rd_base,
   output logic [LIMIT_W-1:0] rd_limit,
   output logic               rd_gran,
   output logic [PL_W-1:0]    rd_dpl,
   output logic [PL_W-1:0]    rd_rpl
);

   logic [AW-1:0]      base_q  [NUM_SEGS];
   logic [LIMIT_W-1:0] limit_q [NUM_SEGS];
   logic [PL_W-1:0]    dpl_q   [NUM_SEGS];
   logic [PL_W-1:0]    rpl_q   [NUM_SEGS];
   logic               gran_q  [NUM_SEGS];
   logic               ok_q    [NUM_SEGS];

   logic sel_null;
   assign sel_null = (wr_selector[SEL_W-1:PL_W] == '0);

   for (genvar g = 0; g < NUM_SEGS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g]  <= '0;
            limit_q[g] <= '0;
            dpl_q[g]   <= '0;
            rpl_q[g]   <= '0;
            gran_q[g]  <= 1'b0;
            ok_q[g]    <= 1'b0;
         end else if (wr_en && int'(wr_seg) == g) begin
            base_q[g]  <= wr_base;
            limit_q[g] <= wr_limit;
            dpl_q[g]   <= wr_dpl;
            rpl_q[g]   <= wr_selector[PL_W-1:0];
            gran_q[g]  <= wr_gran;
            ok_q[g]    <= wr_present && !sel_null;
         end
      end
   end

   always_comb begin
      rd_usable = 1'b0;
      rd_base   = '0;
      rd_limit  = '0;
      rd_gran   = 1'b0;
      rd_dpl    = '0;
      rd_rpl    = '0;
      for (int i = 0; i < NUM_SEGS; i++) begin
         if (int'(rd_seg) == i) begin
            rd_usable = ok_q[i];
            rd_base   = base_q[i];
            rd_limit  = limit_q[i];
            rd_gran   = gran_q[i];
            rd_dpl    = dpl_q[i];
            rd_rpl    = rpl_q[i];
         end
      end
   end

   // R6
   wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && ($past(wr_seg) == rd_seg) && (int'(rd_seg) < NUM_SEGS))
      |-> (rd_base == $past(wr_base) && rd_limit == $past(wr_limit)));

   // R7
   oor_unusable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_seg) >= NUM_SEGS) |-> !rd_usable);

endmodule

// File: rtl/seg_offset_gen.sv
module seg_offset_gen
   import seg_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SCALE_W   = 2,
   parameter bit HAS_SCALE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode,
   input  logic [AW-1:0]      base,
   input  logic [AW-1:0]      index,
   input  logic [SCALE_W-1:0] scale,
   input  logic [AW-1:0]      disp,
   input  logic [AW-1:0]      pc,
   output logic [AW-1:0]      offset,
   output logic               bypass
);

   logic [AW-1:0] scaled;

   if (HAS_SCALE) begin : g_shift
      assign scaled = index << scale;
   end else begin : g_noshift
      logic unused_scale;
      assign unused_scale = ^scale;
      assign scaled = index;
   end

   always_comb begin
      case (mode)
         AM_BASE:       offset = base;
         AM_BASE_DISP:  offset = base + disp;
         AM_SIDX_DISP:  offset = scaled + disp;
         AM_BIDX_DISP:  offset = base + index + disp;
         AM_BSIDX_DISP: offset = base + scaled + disp;
         AM_REL:        offset = pc + disp;
         default:       offset = disp;
      endcase
   end

   assign bypass = (mode == AM_REL);

   // R3
   base_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AM_BASE_DISP) |-> (offset - disp == base));

   // R5
   rel_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (offset - disp == pc));

endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
   import seg_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LIMIT_W    = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int PL_W       = 2,
   parameter bit HAS_GRAN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bypass,
   input  logic               usable,
   input  logic [PL_W-1:0]    cpl,
   input  logic [PL_W-1:0]    rpl,
   input  logic [PL_W-1:0]    dpl,
   input  logic               gran,
   input  logic [LIMIT_W-1:0] limit,
   input  logic [AW-1:0]      offset,
   output fkind_e             kind
);

   localparam logic [AW-1:0] LOW_MASK = (AW'(1) << GRAN_SHIFT) - AW'(1);

   logic [AW-1:0]   lim_ext;
   logic [AW-1:0]   eff_limit;
   logic [PL_W-1:0] eff_pl;

   assign lim_ext = AW'(limit);

   if (HAS_GRAN) begin : g_gran
      assign eff_limit = gran ? ((lim_ext << GRAN_SHIFT) | LOW_MASK) : lim_ext;
   end else begin : g_nogran
      logic unused_gran;
      assign unused_gran = gran;
      assign eff_limit = lim_ext;
   end

   assign eff_pl = (cpl > rpl) ? cpl : rpl;

   always_comb begin
      if (bypass)                kind = FK_NONE;
      else if (!usable)          kind = FK_ABSENT;
      else if (eff_pl > dpl)     kind = FK_PRIV;
      else if (offset > eff_limit) kind = FK_LIMIT;
      else                       kind = FK_NONE;
   end

   // R8
   priv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FK_PRIV) |-> (cpl > dpl || rpl > dpl));

   // R9
   limit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == FK_LIMIT) |-> (offset > lim_ext));

endmodule

// File: rtl/seg_linear_unit.sv
module seg_linear_unit
   import seg_pkg::*;
#(
   parameter int NUM_SEGS   = 6,
   parameter int AW         = 32,
   parameter int SEL_W      = 16,
   parameter int LIMIT_W    = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int SCALE_W    = 2,
   parameter int PL_W       = 2,
   parameter bit HAS_GRAN   = 1'b1,
   parameter bit HAS_SCALE  = 1'b1,
   localparam int SEG_W     = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               desc_wr_en,
   input  logic [SEG_W-1:0]   desc_wr_seg,
   input  logic [SEL_W-1:0]   desc_wr_selector,
   input  logic [AW-1:0]      desc_wr_base,
   input  logic [LIMIT_W-1:0] desc_wr_limit,
   input  logic               desc_wr_gran,
   input  logic [PL_W-1:0]    desc_wr_dpl,
   input  logic               desc_wr_present,
   input  logic               req_valid,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [2:0]         req_mode,
   input  logic [AW-1:0]      req_base,
   input  logic [AW-1:0]      req_index,
   input  logic [SCALE_W-1:0] req_scale,
   input  logic [AW-1:0]      req_disp,
   input  logic [AW-1:0]      req_pc,
   input  logic [PL_W-1:0]    req_cpl,
   output logic               lin_valid,
   output logic [AW-1:0]      lin_addr,
   output logic               fault,
   output logic [1:0]         fault_kind
);

   if (NUM_SEGS < 1) begin : g_bad_segs
      $error("NUM_SEGS must be at least 1");
   end
   if (LIMIT_W + GRAN_SHIFT > AW) begin : g_bad_limit
      $error("scaled limit wider than address");
   end
   if (SEL_W <= PL_W) begin : g_bad_sel
      $error("selector too narrow for privilege field");
   end

   logic               c_usable, c_gran, o_bypass;
   logic [AW-1:0]      c_base, o_offset, addr_c;
   logic [LIMIT_W-1:0] c_limit;
   logic [PL_W-1:0]    c_dpl, c_rpl;
   fkind_e             kind_c, kind_q;
   logic               valid_q;
   logic [AW-1:0]      addr_q;

   seg_desc_cache #(
      .NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W), .AW(AW),
      .SEL_W(SEL_W), .LIMIT_W(LIMIT_W), .PL_W(PL_W)
   ) u_cache (
      .clk(clk), .rst_n(rst_n),
      .wr_en(desc_wr_en), .wr_seg(desc_wr_seg), .wr_selector(desc_wr_selector),
      .wr_base(desc_wr_base), .wr_limit(desc_wr_limit), .wr_gran(desc_wr_gran),
      .wr_dpl(desc_wr_dpl), .wr_present(desc_wr_present),
      .rd_seg(req_seg), .rd_usable(c_usable), .rd_base(c_base),
      .rd_limit(c_limit), .rd_gran(c_gran), .rd_dpl(c_dpl), .rd_rpl(c_rpl)
   );

   seg_offset_gen #(
      .AW(AW), .SCALE_W(SCALE_W), .HAS_SCALE(HAS_SCALE)
   ) u_off (
      .clk(clk), .rst_n(rst_n),
      .mode(req_mode), .base(req_base), .index(req_index), .scale(req_scale),
      .disp(req_disp), .pc(req_pc), .offset(o_offset), .bypass(o_bypass)
   );

   seg_access_chk #(
      .AW(AW), .LIMIT_W(LIMIT_W), .GRAN_SHIFT(GRAN_SHIFT),
      .PL_W(PL_W), .HAS_GRAN(HAS_GRAN)
   ) u_chk (
      .clk(clk), .rst_n(rst_n),
      .bypass(o_bypass), .usable(c_usable), .cpl(req_cpl), .rpl(c_rpl),
      .dpl(c_dpl), .gran(c_gran), .limit(c_limit), .offset(o_offset),
      .kind(kind_c)
   );

   assign addr_c = o_bypass ? o_offset : (c_base + o_offset);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         kind_q  <= FK_NONE;
      end else begin
         valid_q <= req_valid;
         if (req_valid) begin
            addr_q <= addr_c;
            kind_q <= kind_c;
         end else begin
            kind_q <= FK_NONE;
         end
      end
   end

   assign lin_valid  = valid_q;
   assign lin_addr   = addr_q;
   assign fault_kind = kind_q;
   assign fault      = (kind_q != FK_NONE);

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> lin_valid);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!lin_valid && !fault && $stable(lin_addr)));

   // R5
   rel_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == AM_REL) |=> !fault);

   // R7
   absent_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode != AM_REL && int'(req_seg) >= NUM_SEGS) |=> (fault_kind == FK_ABSENT));

   // R10
   fault_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> lin_valid);

endmodule

// File: tb/sim_seg_linear_unit.sv
module sim_seg_linear_unit;

   typedef struct packed {
      logic [3:0]  rq;
      logic [2:0]  seg;
      logic [2:0]  mode;
      logic [31:0] base;
      logic [31:0] idx;
      logic [1:0]  scale;
      logic [31:0] disp;
      logic [31:0] pc;
      logic [1:0]  cpl;
      logic [31:0] ea;
      logic [1:0]  ek;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      // R3 every mode on slot 0 (base 0x10000)
      '{4'd3, 3'd0, 3'd0, 32'h0,   32'h0,  2'd0, 32'h100, 32'h0, 2'd0, 32'h10100, 2'd0},
      '{4'd3, 3'd0, 3'd1, 32'h200, 32'h0,  2'd0, 32'h0,   32'h0, 2'd0, 32'h10200, 2'd0},
      '{4'd3, 3'd0, 3'd2, 32'h200, 32'h0,  2'd0, 32'h34,  32'h0, 2'd0, 32'h10234, 2'd0},
      '{4'd3, 3'd0, 3'd3, 32'h0,   32'h10, 2'd3, 32'h4,   32'h0, 2'd0, 32'h10084, 2'd0},
      '{4'd3, 3'd0, 3'd4, 32'h100, 32'h20, 2'd3, 32'h1,   32'h0, 2'd0, 32'h10121, 2'd0},
      '{4'd3, 3'd0, 3'd5, 32'h100, 32'h20, 2'd2, 32'h1,   32'h0, 2'd0, 32'h10181, 2'd0},
      // R9 byte limit edge and one past, then 4 KB granular edge
      '{4'd9, 3'd0, 3'd0, 32'h0,   32'h0,  2'd0, 32'hFFF,   32'h0, 2'd0, 32'h10FFF,    2'd0},
      '{4'd9, 3'd0, 3'd0, 32'h0,   32'h0,  2'd0, 32'h1000,  32'h0, 2'd0, 32'h11000,    2'd3},
      '{4'd9, 3'd1, 3'd0, 32'h0,   32'h0,  2'd0, 32'hFFFF,  32'h0, 2'd0, 32'h8000FFFF, 2'd0},
      '{4'd9, 3'd1, 3'd0, 32'h0,   32'h0,  2'd0, 32'h10000, 32'h0, 2'd0, 32'h80010000, 2'd3},
      // R8 privilege: cpl above dpl, requested level within, cpl fails
      '{4'd8, 3'd1, 3'd0, 32'h0,   32'h0,  2'd0, 32'h10,  32'h0, 2'd1, 32'h80000010, 2'd2},
      '{4'd8, 3'd2, 3'd0, 32'h0,   32'h0,  2'd0, 32'h0,   32'h0, 2'd0, 32'h10,       2'd0},
      '{4'd8, 3'd2, 3'd0, 32'h0,   32'h0,  2'd0, 32'h0,   32'h0, 2'd3, 32'h10,       2'd2},
      // R7 absent beats privilege; unwritten slot; slot 6
      '{4'd7, 3'd3, 3'd0, 32'h0,   32'h0,  2'd0, 32'h0,   32'h0, 2'd3, 32'h2000, 2'd1},
      '{4'd7, 3'd5, 3'd0, 32'h0,   32'h0,  2'd0, 32'h0,   32'h0, 2'd0, 32'h0,    2'd1},
      '{4'd7, 3'd6, 3'd0, 32'h0,   32'h0,  2'd0, 32'h0,   32'h0, 2'd0, 32'h0,    2'd1},
      // R4 base+offset wraps
      '{4'd4, 3'd4, 3'd0, 32'h0,   32'h0,  2'd0, 32'h20,  32'h0, 2'd3, 32'h10, 2'd0},
      // R5 relative on an absent slot
      '{4'd5, 3'd3, 3'd6, 32'h0,   32'h0,  2'd0, 32'h40,  32'h12340000, 2'd3, 32'h12340040, 2'd0},
      // R4 offset sum wraps
      '{4'd4, 3'd2, 3'd5, 32'hFFFFFFFF, 32'h1, 2'd0, 32'h1, 32'h0, 2'd0, 32'h11, 2'd0},
      // R3 reserved code acts as displacement
      '{4'd3, 3'd0, 3'd7, 32'h0,   32'h0,  2'd0, 32'h10,  32'h0, 2'd0, 32'h10010, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        desc_wr_en = 1'b0;
   logic [2:0]  desc_wr_seg = '0;
   logic [15:0] desc_wr_selector = '0;
   logic [31:0] desc_wr_base = '0;
   logic [19:0] desc_wr_limit = '0;
   logic        desc_wr_gran = 1'b0;
   logic [1:0]  desc_wr_dpl = '0;
   logic        desc_wr_present = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_seg = '0;
   logic [2:0]  req_mode = '0;
   logic [31:0] req_base = '0;
   logic [31:0] req_index = '0;
   logic [1:0]  req_scale = '0;
   logic [31:0] req_disp = '0;
   logic [31:0] req_pc = '0;
   logic [1:0]  req_cpl = '0;
   logic        lin_valid;
   logic [31:0] lin_addr;
   logic        fault;
   logic [1:0]  fault_kind;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   seg_linear_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .desc_wr_en(desc_wr_en), .desc_wr_seg(desc_wr_seg),
      .desc_wr_selector(desc_wr_selector), .desc_wr_base(desc_wr_base),
      .desc_wr_limit(desc_wr_limit), .desc_wr_gran(desc_wr_gran),
      .desc_wr_dpl(desc_wr_dpl), .desc_wr_present(desc_wr_present),
      .req_valid(req_valid), .req_seg(req_seg), .req_mode(req_mode),
      .req_base(req_base), .req_index(req_index), .req_scale(req_scale),
      .req_disp(req_disp), .req_pc(req_pc), .req_cpl(req_cpl),
      .lin_valid(lin_valid), .lin_addr(lin_addr), .fault(fault),
      .fault_kind(fault_kind)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [2:0] s, input logic [15:0] sel, input logic [31:0] b,
                       input logic [19:0] lim, input logic g, input logic [1:0] d, input logic p);
      desc_wr_en = 1'b1; desc_wr_seg = s; desc_wr_selector = sel; desc_wr_base = b;
      desc_wr_limit = lim; desc_wr_gran = g; desc_wr_dpl = d; desc_wr_present = p;
      @(negedge clk);
      desc_wr_en = 1'b0;
   endtask

   task automatic ask(input logic [2:0] s, input logic [2:0] m, input logic [31:0] b,
                      input logic [31:0] ix, input logic [1:0] sc, input logic [31:0] dp,
                      input logic [31:0] p, input logic [1:0] c);
      req_valid = 1'b1; req_seg = s; req_mode = m; req_base = b; req_index = ix;
      req_scale = sc; req_disp = dp; req_pc = p; req_cpl = c;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 lin_valid", {31'b0, lin_valid}, 32'h0);
      chk("R1 lin_addr", lin_addr, 32'h0);
      chk("R1 fault", {30'b0, fault_kind}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 slot 0 unusable straight after reset
      ask(3'd0, 3'd0, 32'h0, 32'h0, 2'd0, 32'h0, 32'h0, 2'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 fresh slot absent", {30'b0, fault_kind}, 32'h1);

      // R6 descriptor loads
      load(3'd0, 16'h0008, 32'h00010000, 20'h00FFF, 1'b0, 2'd3, 1'b1);
      load(3'd1, 16'h0010, 32'h80000000, 20'h0000F, 1'b1, 2'd0, 1'b1);
      load(3'd2, 16'h0019, 32'h00000010, 20'hFFFFF, 1'b1, 2'd2, 1'b1);
      load(3'd3, 16'h0020, 32'h00002000, 20'h00000, 1'b0, 2'd0, 1'b0);
      load(3'd4, 16'h002B, 32'hFFFFFFF0, 20'hFFFFF, 1'b1, 2'd3, 1'b1);

      for (int i = 0; i < NV; i++) begin
         ask(VECS[i].seg, VECS[i].mode, VECS[i].base, VECS[i].idx, VECS[i].scale,
             VECS[i].disp, VECS[i].pc, VECS[i].cpl);
         @(negedge clk);
         chk($sformatf("vec%0d R%0d addr", i, VECS[i].rq), lin_addr, VECS[i].ea);
         chk($sformatf("vec%0d R%0d kind", i, VECS[i].rq), {30'b0, fault_kind}, {30'b0, VECS[i].ek});
         // R10 fault flag tracks the code
         chk($sformatf("vec%0d R10 fault", i), {31'b0, fault}, {31'b0, (VECS[i].ek != 2'd0)});
         // R2 one-cycle latency
         chk($sformatf("vec%0d R2 valid", i), {31'b0, lin_valid}, 32'h1);
      end

      // R2 idle cycle: valid low, address held
      req_valid = 1'b0;
      @(negedge clk);
      chk("R2 idle valid", {31'b0, lin_valid}, 32'h0);
      chk("R2 idle addr hold", lin_addr, 32'h10010);
      chk("R2 idle fault", {31'b0, fault}, 32'h0);

      // R6 write and request in the same cycle: old base is used
      ask(3'd0, 3'd0, 32'h0, 32'h0, 2'd0, 32'h10, 32'h0, 2'd0);
      load(3'd0, 16'h0008, 32'h00050000, 20'h00FFF, 1'b0, 2'd3, 1'b1);
      chk("R6 same-cycle old base", lin_addr, 32'h00010010);
      @(negedge clk);
      chk("R6 next-cycle new base", lin_addr, 32'h00050010);

      // R7 null selector makes a present slot absent
      req_valid = 1'b0;
      load(3'd2, 16'h0001, 32'h00000010, 20'hFFFFF, 1'b1, 2'd2, 1'b1);
      ask(3'd2, 3'd0, 32'h0, 32'h0, 2'd0, 32'h0, 32'h0, 2'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 null selector", {30'b0, fault_kind}, 32'h1);

      // R9 granularity off on slot 1: limit is plain 0xF
      load(3'd1, 16'h0010, 32'h80000000, 20'h0000F, 1'b0, 2'd0, 1'b1);
      ask(3'd1, 3'd0, 32'h0, 32'h0, 2'd0, 32'h10, 32'h0, 2'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 byte-granular limit", {30'b0, fault_kind}, 32'h3);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule